// File: doc/BRIEF.md
# Six-Channel Pulse Generator with Lead-In Delay

This block produces six independent pulse-width-modulated outputs from one clock. Each channel is programmed with a high-phase length and a low-phase length, both counted in clock cycles. A period always starts with its high phase. When software turns a channel on, the output can first stay low for a programmable number of cycles. After that the channel runs either forever or for a programmed number of periods, and then switches itself off.

Software reaches the block through a flat 32-bit write/read port. Each channel has two words: a control word, which holds the on/off bit, the lead-in length and the period limit, and a timing word, which holds both phase lengths. A change to the timing of a running channel is held back until the current period completes. Turning a channel off cuts the waveform short at once.

Top module: `lpwm_bank`

## Requirements
- R1: After reset every register reads zero and all six outputs are low.
- R2: Channel n uses two word addresses. The control word at byte address 4*n holds the on bit in bit 31, the lead-in length in bits 30:16 and the period limit in bits 15:0. The timing word at byte address 0x20+4*n holds the high length in bits 31:16 and the low length in bits 15:0. Reading either word returns the value last stored in it.
- R3: A control write that sets bit 31 on a channel that is off starts the channel. In the cycle after that write edge, the output stays low for a number of cycles equal to the lead-in length, and the first high phase follows directly.
- R4: Each period drives the output high for H cycles and then low for L cycles, where H and L are the phase lengths. If H is 0 the output stays low. If L is 0 and H is not 0, the output stays high. If both are 0, the output is low and each cycle counts as one period.
- R5: With a nonzero period limit N, the output stays low once N complete periods have been generated, and the on bit then reads 0. A limit of 0 lets the channel run without end.
- R6: A control write with bit 31 clear to a running channel drives its output low from the next cycle on, even in the middle of a phase.
- R7: A timing write to a running channel takes effect at the start of the next period. If the write lands on the edge at which a period ends, the period that follows still uses the old values, and the new values apply from the period after it.
- R8: A control write that keeps bit 31 set on a running channel neither restarts nor alters the running waveform. It still stores the new lead-in and limit fields.
- R9: If a control write lands on the edge at which the final limited period ends, the on bit reads 0 afterwards, and the lead-in and limit fields take the written values.
- R10: Writes to unmapped or non-word-aligned addresses change nothing, and reads of such addresses return zero.
- R11: A channel's output depends only on its own registers. The outputs of idle channels stay low while another channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| regAddr | input | 8 | Byte address for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for regAddr |
| pwmOut | output | 6 | One waveform output per channel |

## Verification
Two events can fall on the same edge. The first is the automatic shut-off at the end of the last limited period. The second is a software write to the same channel's control word. The bench computes the exact final edge from lead-in plus limit times period and places a control write with bit 31 set on that edge. It then judges the result by reading back the control word, which must show the on bit clear and the new fields stored, and by checking that the output stays low. A second case places a timing write on a period-boundary edge, and the bench checks that the new timing appears one full period later than a mid-period write would make it appear.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned LEAD_W = 15;
  localparam int unsigned REG_W = 1 + LEAD_W + CNT_W;

  // Per-channel strobes and operands from the register side to a channel.
  typedef struct packed {
    logic              start;
    logic              stop;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  reps;
    logic [CNT_W-1:0]  highT;
    logic [CNT_W-1:0]  lowT;
  } chanCmd_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_HIGH, PH_LOW} phase_t;
endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [NUM_CH-1:0] chanDone,
  output chanCmd_t          cmd [NUM_CH]
);
  localparam int unsigned STRIDE    = 4;
  localparam int unsigned TIME_BASE = 8 * STRIDE;
  localparam int unsigned EN_BIT    = REG_W - 1;

  logic [REG_W-1:0] ctrlView [NUM_CH];
  logic [REG_W-1:0] timeView [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              enReg;
    logic [LEAD_W-1:0] leadReg;
    logic [CNT_W-1:0]  repReg;
    logic [REG_W-1:0]  timeReg;
    logic              ctrlHit, timeHit;

    assign ctrlHit = wrEn && (regAddr == ADDR_W'(STRIDE * i));
    assign timeHit = wrEn && (regAddr == ADDR_W'(TIME_BASE + STRIDE * i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enReg   <= 1'b0;
        leadReg <= '0;
        repReg  <= '0;
        timeReg <= '0;
      end else begin
        if (ctrlHit) begin
          leadReg <= wrData[EN_BIT-1:CNT_W];
          repReg  <= wrData[CNT_W-1:0];
        end
        if (chanDone[i])  enReg <= 1'b0;
        else if (ctrlHit) enReg <= wrData[EN_BIT];
        if (timeHit) timeReg <= wrData;
      end
    end

    assign ctrlView[i] = {enReg, leadReg, repReg};
    assign timeView[i] = timeReg;

    assign cmd[i].start = ctrlHit && wrData[EN_BIT] && !enReg;
    assign cmd[i].stop  = ctrlHit && !wrData[EN_BIT] && enReg;
    assign cmd[i].lead  = wrData[EN_BIT-1:CNT_W];
    assign cmd[i].reps  = wrData[CNT_W-1:0];
    assign cmd[i].highT = timeReg[REG_W-1:CNT_W];
    assign cmd[i].lowT  = timeReg[CNT_W-1:0];

    // R5
    done_en_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanDone[i] |-> enReg);
    // R5
    en_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanDone[i] |=> !enReg);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == ADDR_W'(STRIDE * i))             rdData = ctrlView[i];
      if (regAddr == ADDR_W'(TIME_BASE + STRIDE * i)) rdData = timeView[i];
    end
  end
endmodule

// File: rtl/lpwm_chan.sv
module lpwm_chan
  import lpwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCmd_t cmd,
  output logic     pwmOut,
  output logic     doneStb
);
  phase_t           phase, phaseNxt, bgPhase;
  logic [CNT_W-1:0] cnt, cntNxt, bgCnt;
  logic [CNT_W-1:0] actHigh, actHighNxt, actLow, actLowNxt;
  logic [CNT_W-1:0] repLimit, repLimitNxt, perCnt, perCntNxt;
  logic             phaseEnd, periodEnd, lastPeriod, doBegin;

  always_comb begin
    phaseEnd   = (cnt == '0);
    periodEnd  = phaseEnd && ((phase == PH_HIGH && actLow == '0) || phase == PH_LOW);
    lastPeriod = (repLimit != '0) && (perCnt == repLimit - 1'b1);
    doneStb    = periodEnd && lastPeriod;
  end

  // First phase of a new period, taken from the shadow timing.
  always_comb begin
    if (cmd.highT != '0) begin
      bgPhase = PH_HIGH;
      bgCnt   = cmd.highT - 1'b1;
    end else begin
      bgPhase = PH_LOW;
      bgCnt   = (cmd.lowT != '0) ? cmd.lowT - 1'b1 : '0;
    end
  end

  always_comb begin
    phaseNxt    = phase;
    cntNxt      = cnt;
    actHighNxt  = actHigh;
    actLowNxt   = actLow;
    repLimitNxt = repLimit;
    perCntNxt   = perCnt;
    doBegin     = 1'b0;
    if (cmd.stop) begin
      phaseNxt = PH_IDLE;
    end else if (cmd.start) begin
      repLimitNxt = cmd.reps;
      perCntNxt   = '0;
      if (cmd.lead != '0) begin
        phaseNxt = PH_LEAD;
        cntNxt   = CNT_W'(cmd.lead) - 1'b1;
      end else begin
        doBegin = 1'b1;
      end
    end else begin
      unique case (phase)
        PH_LEAD: if (phaseEnd) doBegin = 1'b1; else cntNxt = cnt - 1'b1;
        PH_HIGH, PH_LOW: begin
          if (!phaseEnd) begin
            cntNxt = cnt - 1'b1;
          end else if (phase == PH_HIGH && actLow != '0) begin
            phaseNxt = PH_LOW;
            cntNxt   = actLow - 1'b1;
          end else if (lastPeriod) begin
            phaseNxt = PH_IDLE;
          end else begin
            perCntNxt = perCnt + 1'b1;
            doBegin   = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (doBegin) begin
      actHighNxt = cmd.highT;
      actLowNxt  = cmd.lowT;
      phaseNxt   = bgPhase;
      cntNxt     = bgCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      actHigh  <= '0;
      actLow   <= '0;
      repLimit <= '0;
      perCnt   <= '0;
    end else begin
      phase    <= phaseNxt;
      cnt      <= cntNxt;
      actHigh  <= actHighNxt;
      actLow   <= actLowNxt;
      repLimit <= repLimitNxt;
      perCnt   <= perCntNxt;
    end
  end

  assign pwmOut = (phase == PH_HIGH);

  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stop |=> !pwmOut);
  // R3
  lead_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && cmd.lead != '0) |=> !pwmOut);
  // R4
  high_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH) |-> (cnt < actHigh));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && !cmd.stop) |=> (phase == PH_IDLE));
endmodule

// File: rtl/lpwm_bank.sv
module lpwm_bank
  import lpwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCmd_t          cmd [NUM_CH];
  logic [NUM_CH-1:0] chanDone;

  lpwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .chanDone(chanDone), .cmd(cmd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    lpwm_chan chan_i (
      .clk(clk), .rstN(rstN), .cmd(cmd[i]),
      .pwmOut(pwmOut[i]), .doneStb(chanDone[i])
    );
  end
endmodule

// File: tb/lpwm_bank_tb_top.sv
module lpwm_bank_tb_top;
  localparam int CLK_NS = 8;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [7:0]  regAddr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [5:0]  pwmOut;
  int nCmp = 0, nBad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  lpwm_bank dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
                   .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut));

  function automatic logic model(int c, int ld, int h, int lo, int n);
    int d, p;
    if (c < ld) return 1'b0;
    d = c - ld;
    p = (h + lo == 0) ? 1 : h + lo;
    if (n != 0 && d >= n * p) return 1'b0;
    return (d % p) < h;
  endfunction

  function automatic logic [5:0] vec(int ch, logic b);
    logic [5:0] v = '0;
    v[ch] = b;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    wrEn = 1'b0; regAddr = a; #1; d = rdData;
  endtask

  task automatic stopCh(int ch);
    @(negedge clk); wr(8'(4*ch), 32'h0);
    @(negedge clk); wrEn = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int idx = 0;
    rstN = 1'b0; wrEn = 1'b0; regAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 64; a += 4) begin
      rd(8'(a), r); chk($sformatf("R1 addr %0h", a), r, 32'h0);
    end
    chk("R1 outputs", 32'(pwmOut), 32'h0);

    // R10: unmapped and unaligned writes
    @(negedge clk); wr(8'h18, 32'hFFFF_FFFF);
    @(negedge clk); wr(8'h01, 32'hFFFF_FFFF);
    @(negedge clk); wr(8'h21, 32'hFFFF_FFFF);
    @(negedge clk); wr(8'h38, 32'hFFFF_FFFF);
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    rd(8'h00, r); chk("R10 ctrl0 untouched", r, 32'h0);
    rd(8'h20, r); chk("R10 time0 untouched", r, 32'h0);
    rd(8'h18, r); chk("R10 unmapped read", r, 32'h0);
    rd(8'h38, r); chk("R10 unmapped read hi", r, 32'h0);
    chk("R10 outputs", 32'(pwmOut), 32'h0);

    // R2 R3 R4 R5 R6 R11: sweep
    for (int h = 0; h < 4; h++)
      for (int lo = 0; lo < 3; lo++)
        for (int li = 0; li < 2; li++)
          for (int ni = 0; ni < 2; ni++) begin
            int ld = li * 2, n = ni * 2, ch = idx % 6, p, fin;
            logic enExp;
            idx++;
            p = (h + lo == 0) ? 1 : h + lo;
            fin = ld + n * p;
            @(negedge clk); wr(8'(32 + 4*ch), {16'(h), 16'(lo)});
            @(negedge clk); wr(8'(4*ch), {1'b1, 15'(ld), 16'(n)});
            for (int c = 0; c < 30; c++) begin
              @(negedge clk); wrEn = 1'b0;
              chk($sformatf("R3 R4 R5 R11 ch%0d h%0d l%0d ld%0d n%0d c%0d", ch, h, lo, ld, n, c),
                  32'(pwmOut), 32'(vec(ch, model(c, ld, h, lo, n))));
            end
            enExp = !(n != 0 && fin <= 29);
            rd(8'(4*ch), r);
            chk($sformatf("R2 R5 ctrl ch%0d", ch), r, {enExp, 15'(ld), 16'(n)});
            rd(8'(32 + 4*ch), r);
            chk($sformatf("R2 timing ch%0d", ch), r, {16'(h), 16'(lo)});
            wr(8'(4*ch), 32'h0);
            @(negedge clk); wrEn = 1'b0;
            chk($sformatf("R6 stop ch%0d", ch), 32'(pwmOut), 32'h0);
          end

    // R7: timing write in mid-period
    @(negedge clk); wr(8'h28, {16'd3, 16'd3});
    @(negedge clk); wr(8'h08, 32'h8000_0000);
    for (int c = 0; c < 16; c++) begin
      logic e;
      @(negedge clk); wrEn = 1'b0;
      e = (c < 6) ? model(c, 0, 3, 3, 0) : model(c - 6, 0, 1, 1, 0);
      chk($sformatf("R7 mid c%0d", c), 32'(pwmOut), 32'(vec(2, e)));
      if (c == 1) wr(8'h28, {16'd1, 16'd1});
    end
    stopCh(2);
    // R7: timing write on the boundary edge
    @(negedge clk); wr(8'h28, {16'd2, 16'd2});
    @(negedge clk); wr(8'h08, 32'h8000_0000);
    for (int c = 0; c < 16; c++) begin
      logic e;
      @(negedge clk); wrEn = 1'b0;
      e = (c < 8) ? model(c, 0, 2, 2, 0) : model(c - 8, 0, 1, 3, 0);
      chk($sformatf("R7 boundary c%0d", c), 32'(pwmOut), 32'(vec(2, e)));
      if (c == 3) wr(8'h28, {16'd1, 16'd3});
    end
    stopCh(2);

    // R8: control rewrite while running
    @(negedge clk); wr(8'h30, {16'd2, 16'd2});
    @(negedge clk); wr(8'h10, 32'h8000_0000);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); wrEn = 1'b0;
      chk($sformatf("R8 c%0d", c), 32'(pwmOut), 32'(vec(4, model(c, 0, 2, 2, 0))));
      if (c == 1) wr(8'h10, {1'b1, 15'd3, 16'd1});
    end
    rd(8'h10, r); chk("R8 fields stored", r, {1'b1, 15'd3, 16'd1});
    stopCh(4);

    // R9: control write on the final edge (done edge ends cycle 4)
    @(negedge clk); wr(8'h2C, {16'd1, 16'd1});
    @(negedge clk); wr(8'h0C, {1'b1, 15'd1, 16'd2});
    for (int c = 0; c < 11; c++) begin
      @(negedge clk); wrEn = 1'b0;
      chk($sformatf("R9 c%0d", c), 32'(pwmOut), 32'(vec(3, model(c, 1, 1, 1, 2))));
      if (c == 4) wr(8'h0C, {1'b1, 15'd5, 16'd7});
      if (c == 6) begin
        rd(8'h0C, r); chk("R9 collision readback", r, {1'b0, 15'd5, 16'd7});
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule